// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Data Cache Lookup

This block is the lookup path of a four-way set-associative first-level data cache. A request carries only the untranslated page-offset part of its address. The set index is taken entirely from those bits, so the tag, valid and data arrays can be read in the request cycle. In the following cycle, address translation supplies the physical frame number and a flag that says whether it is usable. The block compares that frame number with the physical tags it read and reports a hit, a miss or a translation fault. On a hit it also returns the hitting way and the addressed 32-bit word.

Stores are write-through. Every store that has a usable translation is forwarded to the next level in its response cycle, whether it hits or not. A store that hits merges its enabled bytes into the resident line. A store that misses does not allocate a line. Each stored word carries one even-parity bit, which detects errors but cannot correct them. A parity mismatch on the word a hit would return is flagged and handled as a miss.

Lines arrive from outside through a refill port. The refill port writes a whole line, its per-word parity bits and its tag into a chosen set and way, and marks that way valid.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After a synchronous active-high reset, every way of every set is invalid. `rsp_valid` and `wt_valid` are low, and any lookup with a usable translation misses until a refill occurs.
- R2: The set is `req_off[PAGE_BITS-1:OFF_BITS]` and the word within the line is `req_off[OFF_BITS-1:2]`. Bits `req_off[1:0]` do not affect which word is selected.
- R3: The response to a request appears in the next cycle, using the translation inputs of that cycle. When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. When `rsp_valid` is low, all three are low.
- R4: A hit requires three things: the way is valid, its stored tag equals `xl_pfn`, and `xl_ok` is high. On a hit, `rsp_way` gives the way number and `rsp_rdata` gives the addressed word of that line.
- R5: When `xl_ok` is low, the response is a fault. It is neither a hit nor a miss, no write-through is issued, and a store leaves the arrays unchanged.
- R6: A refill writes the tag, all words and their parity bits into way `rf_way` of set `rf_set`, and makes that way valid. This replaces any line that was there before.
- R7: A store that hits replaces only the bytes whose `req_be` bit is set. Bit b selects bits 8b+7..8b. The parity of the word is recomputed. A store that misses allocates nothing.
- R8: Every store with `xl_ok` high raises `wt_valid` in its response cycle, hit or miss. With it, `wt_addr` = {`xl_pfn`, offset}, and `wt_data` and `wt_be` equal the store's data and byte enables.
- R9: The parity bit of a word is the XOR of its 32 bits (even parity). If the addressed word of a matching way fails this check, `rsp_perr` is high, the response is a miss and not a hit, `rsp_rdata` is zero, and a store does not update the line.
- R10: `rsp_rdata` is zero whenever the response is not a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_off | input | PAGE_BITS | Untranslated page-offset bits of the address |
| req_we | input | 1 | Request is a store |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| xl_ok | input | 1 | Translation usable (response cycle) |
| xl_pfn | input | PA_BITS-PAGE_BITS | Physical frame number (response cycle) |
| rf_valid | input | 1 | Refill write strobe |
| rf_set | input | PAGE_BITS-OFF_BITS | Refill target set |
| rf_way | input | log2(WAYS) | Refill target way |
| rf_tag | input | PA_BITS-PAGE_BITS | Refill physical tag |
| rf_line | input | LINE_BYTES*8 | Refill line data, word 0 in the low bits |
| rf_par | input | LINE_BYTES/4 | Refill parity bit for each word |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_fault | output | 1 | Translation fault |
| rsp_perr | output | 1 | Parity error on the matching way |
| rsp_way | output | log2(WAYS) | Hitting way |
| rsp_rdata | output | 32 | Selected word |
| wt_valid | output | 1 | Write-through store issued |
| wt_addr | output | PA_BITS | Physical byte address of the store |
| wt_be | output | 4 | Write-through byte enables |
| wt_data | output | 32 | Write-through data |

## Verification
The bench builds the block with `PAGE_BITS=9`, `PA_BITS=20`, 32-byte lines and four ways. That gives 16 sets and 11-bit tags, so every set, word and way the tests touch can be written down in a few vectors. With so few sets, one set can hold lines from several frames at once. This exercises selection among ways and replacement by refill, and it checks that tag bits never leak into set selection. Refills with a deliberately wrong parity bit produce parity errors on chosen words only. This lets the bench tell a corrupted word apart from clean words in the same line.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_HIT,
        OUT_MISS,
        OUT_FAULT
    } outcome_e;

    // even parity: stored bit equals XOR of the data bits
    function automatic logic even_par(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SETS     = 128,
    parameter int WAYS     = 4,
    parameter int TAG_W    = 20,
    parameter int SET_BITS = 7,
    parameter int WAY_BITS = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_en,
    input  logic [SET_BITS-1:0]            rd_set,
    input  logic                           rf_we,
    input  logic [SET_BITS-1:0]            rf_set,
    input  logic [WAY_BITS-1:0]            rf_way,
    input  logic [TAG_W-1:0]               rf_tag,
    output logic [WAYS-1:0]                rd_vld,
    output logic [WAYS-1:0][TAG_W-1:0]     rd_tag
);
    logic [WAYS-1:0]             vld  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tags [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
            rd_vld <= '0;
        end else begin
            if (rf_we) vld[rf_set][rf_way] <= 1'b1;
            if (rd_en) rd_vld <= vld[rd_set];
        end
    end

    always_ff @(posedge clk) begin
        if (rf_we) tags[rf_set][rf_way] <= rf_tag;
        if (rd_en) rd_tag <= tags[rd_set];
    end

    // R6: a refilled way reads back as valid
    a_r6_refill_marks_valid: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> vld[$past(rf_set)][$past(rf_way)]);

endmodule

// File: rtl/vipt_data_way.sv
module vipt_data_way
    import vipt_pkg::*;
#(
    parameter int SETS      = 128,
    parameter int WORDS     = 8,
    parameter int SET_BITS  = 7,
    parameter int WIDX_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rd_en,
    input  logic [SET_BITS-1:0]         rd_set,
    input  logic [WIDX_BITS-1:0]        rd_word,
    input  logic                        rf_we,
    input  logic [SET_BITS-1:0]         rf_set,
    input  logic [WORDS*WORD_W-1:0]     rf_line,
    input  logic [WORDS-1:0]            rf_par,
    input  logic                        st_we,
    input  logic [SET_BITS-1:0]         st_set,
    input  logic [WIDX_BITS-1:0]        st_word,
    input  logic [WORD_W-1:0]           st_data,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        rd_par
);
    // each entry holds {parity, data}
    logic [WORD_W:0] mem [SETS][WORDS];

    always_ff @(posedge clk) begin
        if (rf_we) begin
            for (int w = 0; w < WORDS; w++)
                mem[rf_set][w] <= {rf_par[w], rf_line[w*WORD_W +: WORD_W]};
        end else if (st_we) begin
            mem[st_set][st_word] <= {even_par(st_data), st_data};
        end
        if (rd_en) {rd_par, rd_data} <= mem[rd_set][rd_word];
    end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int WAYS     = 4,
    parameter int TAG_W    = 20,
    parameter int WAY_BITS = 2
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            pfn,
    input  logic                        pfn_ok,
    output logic [WAYS-1:0]             match,
    output logic                        any,
    output logic [WAY_BITS-1:0]         idx
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = pfn_ok && vld[g] && (tags[g] == pfn);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < WAYS; i++)
            if (match[i]) idx = WAY_BITS'(i);
    end

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int PAGE_BITS  = 12,
    parameter int PA_BITS    = 32,
    parameter int LINE_BYTES = 32,
    parameter int WAYS       = 4,
    localparam int OFF_BITS  = $clog2(LINE_BYTES),
    localparam int SET_BITS  = PAGE_BITS - OFF_BITS,
    localparam int SETS      = 1 << SET_BITS,
    localparam int WORDS     = LINE_BYTES / 4,
    localparam int WIDX_BITS = $clog2(WORDS),
    localparam int TAG_W     = PA_BITS - PAGE_BITS,
    localparam int WAY_BITS  = $clog2(WAYS),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [PAGE_BITS-1:0]  req_off,
    input  logic                  req_we,
    input  logic [3:0]            req_be,
    input  logic [31:0]           req_wdata,
    input  logic                  xl_ok,
    input  logic [TAG_W-1:0]      xl_pfn,
    input  logic                  rf_valid,
    input  logic [SET_BITS-1:0]   rf_set,
    input  logic [WAY_BITS-1:0]   rf_way,
    input  logic [TAG_W-1:0]      rf_tag,
    input  logic [LINE_BITS-1:0]  rf_line,
    input  logic [WORDS-1:0]      rf_par,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_fault,
    output logic                  rsp_perr,
    output logic [WAY_BITS-1:0]   rsp_way,
    output logic [31:0]           rsp_rdata,
    output logic                  wt_valid,
    output logic [PA_BITS-1:0]    wt_addr,
    output logic [3:0]            wt_be,
    output logic [31:0]           wt_data
);
    // request stage registers (array read happens at the same edge)
    logic                  s1_valid, s1_we;
    logic [PAGE_BITS-1:0]  s1_off;
    logic [3:0]            s1_be;
    logic [31:0]           s1_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= req_valid;
        end
        if (req_valid) begin
            s1_off   <= req_off;
            s1_we    <= req_we;
            s1_be    <= req_be;
            s1_wdata <= req_wdata;
        end
    end

    wire [SET_BITS-1:0]  rd_set  = req_off[PAGE_BITS-1:OFF_BITS];
    wire [WIDX_BITS-1:0] rd_word = req_off[OFF_BITS-1:2];
    wire [SET_BITS-1:0]  s1_set  = s1_off[PAGE_BITS-1:OFF_BITS];
    wire [WIDX_BITS-1:0] s1_word = s1_off[OFF_BITS-1:2];

    logic [WAYS-1:0]             way_vld;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][31:0]       way_data;
    logic [WAYS-1:0]             way_par;

    vipt_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
        .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)
    ) u_tags (
        .clk(clk), .rst(rst),
        .rd_en(req_valid), .rd_set(rd_set),
        .rf_we(rf_valid), .rf_set(rf_set), .rf_way(rf_way), .rf_tag(rf_tag),
        .rd_vld(way_vld), .rd_tag(way_tag)
    );

    logic [WAYS-1:0]      match;
    logic                 any_match;
    logic [WAY_BITS-1:0]  hit_idx;

    vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_BITS(WAY_BITS)) u_match (
        .vld(way_vld), .tags(way_tag), .pfn(xl_pfn), .pfn_ok(xl_ok),
        .match(match), .any(any_match), .idx(hit_idx)
    );

    wire [31:0] sel_data = way_data[hit_idx];
    wire        sel_par  = way_par[hit_idx];
    wire        par_bad  = s1_valid && any_match && (even_par(sel_data) != sel_par);

    outcome_e outcome;
    always_comb begin
        if (!s1_valid)                outcome = OUT_NONE;
        else if (!xl_ok)              outcome = OUT_FAULT;
        else if (any_match && !par_bad) outcome = OUT_HIT;
        else                          outcome = OUT_MISS;
    end

    wire        st_hit    = (outcome == OUT_HIT) && s1_we;
    wire [31:0] st_merged = merge_bytes(sel_data, s1_wdata, s1_be);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        vipt_data_way #(
            .SETS(SETS), .WORDS(WORDS), .SET_BITS(SET_BITS), .WIDX_BITS(WIDX_BITS)
        ) u_data (
            .clk(clk),
            .rd_en(req_valid), .rd_set(rd_set), .rd_word(rd_word),
            .rf_we(rf_valid && (rf_way == WAY_BITS'(g))), .rf_set(rf_set),
            .rf_line(rf_line), .rf_par(rf_par),
            .st_we(st_hit && (hit_idx == WAY_BITS'(g))), .st_set(s1_set),
            .st_word(s1_word), .st_data(st_merged),
            .rd_data(way_data[g]), .rd_par(way_par[g])
        );
    end

    assign rsp_valid = (outcome != OUT_NONE);
    assign rsp_hit   = (outcome == OUT_HIT);
    assign rsp_miss  = (outcome == OUT_MISS);
    assign rsp_fault = (outcome == OUT_FAULT);
    assign rsp_perr  = par_bad;
    assign rsp_way   = rsp_hit ? hit_idx : '0;
    assign rsp_rdata = rsp_hit ? sel_data : '0;

    assign wt_valid = s1_valid && s1_we && xl_ok;
    assign wt_addr  = {xl_pfn, s1_off};
    assign wt_be    = s1_be;
    assign wt_data  = s1_wdata;

    // R3: one outcome per response, none without a response
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_perr));
    a_r3_follows_request: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));
    // R4: at most one way can match a frame number
    a_r4_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
    // R5: a fault is never forwarded downstream
    a_r5_fault_no_forward: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> !wt_valid);
    // R8: write-through only accompanies a translated response
    a_r8_wt_in_response: assert property (@(posedge clk) disable iff (rst)
        wt_valid |-> (rsp_valid && !rsp_fault));
    // R9: a parity error never reports a hit
    a_r9_perr_is_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_perr |-> (rsp_miss && !rsp_hit));

endmodule

// File: tb/sim_vipt_l1_lookup.sv
module sim_vipt_l1_lookup;
    localparam int PAGE_BITS = 9;
    localparam int PA_BITS   = 20;
    localparam int LB        = 32;
    localparam int WAYS      = 4;
    localparam int TAG_W     = PA_BITS - PAGE_BITS;   // 11
    localparam int SET_BITS  = PAGE_BITS - 5;         // 4
    localparam int WORDS     = LB / 4;                // 8

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, req_valid, req_we, xl_ok, rf_valid;
    logic [PAGE_BITS-1:0] req_off;
    logic [3:0] req_be;
    logic [31:0] req_wdata;
    logic [TAG_W-1:0] xl_pfn, rf_tag;
    logic [SET_BITS-1:0] rf_set;
    logic [1:0] rf_way;
    logic [LB*8-1:0] rf_line;
    logic [WORDS-1:0] rf_par;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_perr, wt_valid;
    logic [1:0] rsp_way;
    logic [31:0] rsp_rdata, wt_data;
    logic [PA_BITS-1:0] wt_addr;
    logic [3:0] wt_be;

    vipt_l1_lookup #(.PAGE_BITS(PAGE_BITS), .PA_BITS(PA_BITS), .LINE_BYTES(LB), .WAYS(WAYS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_off(req_off), .req_we(req_we),
        .req_be(req_be), .req_wdata(req_wdata), .xl_ok(xl_ok), .xl_pfn(xl_pfn),
        .rf_valid(rf_valid), .rf_set(rf_set), .rf_way(rf_way), .rf_tag(rf_tag),
        .rf_line(rf_line), .rf_par(rf_par), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_perr(rsp_perr), .rsp_way(rsp_way),
        .rsp_rdata(rsp_rdata), .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_be(wt_be),
        .wt_data(wt_data)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] model [16][4][8];

    logic o_valid, o_hit, o_miss, o_fault, o_perr, o_wtv;
    logic [1:0] o_way;
    logic [31:0] o_rdata, o_wtd;
    logic [PA_BITS-1:0] o_wta;
    logic [3:0] o_wtb;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lw(input int tag, input int set, input int w);
        return {tag[10:0], set[3:0], w[2:0], 14'h1A5B};
    endfunction

    function automatic logic [PAGE_BITS-1:0] mko(input int set, input int w, input int byt);
        return {set[3:0], w[2:0], byt[1:0]};
    endfunction

    task automatic refill(input int set, input int way, input int tag, input int bad);
        @(negedge clk);
        rf_valid = 1'b1; rf_set = set[3:0]; rf_way = way[1:0]; rf_tag = tag[10:0];
        for (int i = 0; i < WORDS; i++) begin
            rf_line[i*32 +: 32] = lw(tag, set, i);
            rf_par[i] = (^lw(tag, set, i)) ^ (i == bad);
            model[set][way][i] = lw(tag, set, i);
        end
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic access(input logic [PAGE_BITS-1:0] off, input logic we, input logic [3:0] be,
                          input logic [31:0] wd, input int pfn, input logic ok);
        @(negedge clk);
        req_valid = 1'b1; req_off = off; req_we = we; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; xl_ok = ok; xl_pfn = pfn[10:0];
        #1;
        o_valid = rsp_valid; o_hit = rsp_hit; o_miss = rsp_miss; o_fault = rsp_fault;
        o_perr = rsp_perr; o_way = rsp_way; o_rdata = rsp_rdata; o_wtv = wt_valid;
        o_wta = wt_addr; o_wtd = wt_data; o_wtb = wt_be;
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    // vector: off(9) pfn(11) ok(1) code(2: 1 hit, 2 miss, 3 fault) way(2)
    function automatic logic [24:0] mk(input int set, input int w, input int byt, input int pfn,
                                       input int ok, input int code, input int way);
        return {mko(set, w, byt), pfn[10:0], ok[0], code[1:0], way[1:0]};
    endfunction

    localparam logic [24:0] VEC [8] = '{
        mk(3, 1, 0, 'h055, 1, 1, 0),
        mk(3, 7, 0, 'h1A0, 1, 1, 2),
        mk(3, 0, 0, 'h0AA, 1, 2, 0),
        mk(5, 4, 0, 'h055, 1, 1, 1),
        mk(4, 4, 0, 'h055, 1, 2, 0),
        mk(0, 6, 0, 'h7FF, 1, 1, 3),
        mk(3, 1, 0, 'h055, 0, 3, 0),
        mk(3, 2, 3, 'h055, 1, 1, 0)
    };

    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] merged;
        rst = 1'b1; req_valid = 0; req_off = '0; req_we = 0; req_be = '0; req_wdata = '0;
        xl_ok = 0; xl_pfn = '0; rf_valid = 0; rf_set = '0; rf_way = '0; rf_tag = '0;
        rf_line = '0; rf_par = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 wt_valid after reset", wt_valid, 0);
        chk("R3 no outcome while idle", {rsp_hit, rsp_miss, rsp_fault}, 0);

        access(mko(3, 1, 0), 0, 0, 0, 'h055, 1);
        chk("R1 empty cache misses", {o_valid, o_hit, o_miss}, 3'b101);

        refill(3, 0, 'h055, -1);
        refill(3, 2, 'h1A0, -1);
        refill(5, 1, 'h055, -1);
        refill(0, 3, 'h7FF, -1);
        refill(7, 0, 'h123, 2);

        // R2 R4 R5 table walk
        for (int i = 0; i < 8; i++) begin
            logic [24:0] v;
            int s, w, way;
            v = VEC[i];
            access(v[24:16], 0, 0, 0, int'(v[15:5]), v[4]);
            s = int'(v[24:21]); w = int'(v[20:18]); way = int'(v[1:0]);
            chk("R3 response valid", o_valid, 1);
            chk("R4 outcome code", {o_hit, o_miss, o_fault}, v[3:2] == 1 ? 3'b100 : v[3:2] == 2 ? 3'b010 : 3'b001);
            if (v[3:2] == 1) begin
                chk("R4 hit way", o_way, v[1:0]);
                chk("R2 R4 selected word", o_rdata, model[s][way][w]);
            end else begin
                chk("R10 rdata zero", o_rdata, 0);
            end
            if (v[3:2] == 3) chk("R5 fault no write-through", o_wtv, 0);
        end

        // R7 R8 store hit
        merged = mrg(model[3][0][1], 32'h1122_3344, 4'b0101);
        access(mko(3, 1, 2), 1, 4'b0101, 32'h1122_3344, 'h055, 1);
        chk("R7 store hit", o_hit, 1);
        chk("R8 wt_valid on hit", o_wtv, 1);
        chk("R8 wt_addr", o_wta, {11'h055, mko(3, 1, 2)});
        chk("R8 wt_data", o_wtd, 32'h1122_3344);
        chk("R8 wt_be", o_wtb, 4'b0101);
        model[3][0][1] = merged;
        access(mko(3, 1, 0), 0, 0, 0, 'h055, 1);
        chk("R7 merged bytes", o_rdata, merged);

        // R7 R8 store miss, no allocation
        access(mko(3, 1, 0), 1, 4'hF, 32'hDEAD_BEEF, 'h0AA, 1);
        chk("R8 wt on miss", {o_miss, o_wtv}, 2'b11);
        chk("R8 wt_addr on miss", o_wta, {11'h0AA, mko(3, 1, 0)});
        access(mko(3, 1, 0), 0, 0, 0, 'h0AA, 1);
        chk("R7 miss allocates nothing", o_miss, 1);
        access(mko(3, 1, 0), 0, 0, 0, 'h055, 1);
        chk("R7 resident line untouched", o_rdata, merged);

        // R5 faulting store
        access(mko(3, 1, 0), 1, 4'hF, 32'h0BAD_F00D, 'h055, 0);
        chk("R5 faulting store", {o_fault, o_hit, o_miss, o_wtv}, 4'b1000);
        access(mko(3, 1, 0), 0, 0, 0, 'h055, 1);
        chk("R5 fault left data unchanged", o_rdata, merged);

        // R9 parity
        access(mko(7, 2, 0), 0, 0, 0, 'h123, 1);
        chk("R9 perr flagged", {o_perr, o_miss, o_hit}, 3'b110);
        chk("R9 rdata zero on perr", o_rdata, 0);
        access(mko(7, 3, 0), 0, 0, 0, 'h123, 1);
        chk("R9 clean word hits", {o_perr, o_hit}, 2'b01);
        chk("R9 clean word data", o_rdata, model[7][0][3]);
        access(mko(7, 2, 0), 1, 4'hF, 32'h5555_AAAA, 'h123, 1);
        chk("R9 store on perr is miss", {o_perr, o_miss, o_wtv}, 3'b111);
        access(mko(7, 2, 0), 0, 0, 0, 'h123, 1);
        chk("R9 store not applied", o_perr, 1);

        // R6 refill replaces a line
        refill(3, 0, 'h0AA, -1);
        access(mko(3, 1, 0), 0, 0, 0, 'h055, 1);
        chk("R6 old tag gone", o_miss, 1);
        access(mko(3, 5, 0), 0, 0, 0, 'h0AA, 1);
        chk("R6 new tag hits", {o_hit, o_way}, 3'b100);
        chk("R6 new line data", o_rdata, model[3][0][5]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule